// File: doc/BRIEF.md
# Prioritized Abort Cause Recorder

This block sits beside an address-translation unit and turns the abort conditions raised during one access into architectural fault state. Each cycle it looks at the per-cause fault flags and picks the one with the highest priority. It encodes that cause as a 5-bit status code split across status bits 10 and 3:0. It then writes the result into a data-side status register or an instruction-side status register, depending on which side made the access. Data-side aborts also capture the faulting virtual address. When the access is a cache maintenance operation by address, the address of the instruction that issued it is captured as well.

A translation-class fault that hits an instruction-cache maintenance operation is reported on both sides. The data-side status gets a dedicated maintenance-fault code, and the instruction-side status gets the real cause. The status word also carries two extra fields. One is the domain number, written only when the cause defines it. The other is a bus-error kind bit, set only for external aborts.

Top module: `faultRecorder`

## Requirements
- R1: With several flags high, the recorded cause is the first present in this order, highest first: alignment (flag bit 0), TLB miss (1), external abort on walk (2), translation (3), access flag (4), domain (5), permission (6), precise external (7), imprecise external (8), parity (9), debug event (10).
- R2: The 5-bit code {status[10], status[3:0]} is: alignment 00001, TLB miss 00000, walk external 01100 first level / 01110 second level, translation 00101 section / 00111 page, access flag 00011 / 00110, domain 01001 / 01011, permission 01101 / 01111, precise external 01000, imprecise external 10110, parity 11000, debug 00010. The level input selects second level and the page input selects page.
- R3: Status bits 7:4 of the data-side register hold the domain input when the cause defines it, and zero otherwise. The cause defines it for second-level walk external, page translation, access flag, domain, permission and debug. The instruction-side register always has zero there.
- R4: Status bit 12 equals the bus-error kind input (1 = slave error, 0 = decode error) for the three external-abort causes and is 0 for every other cause.
- R5: A data-side abort writes the data status register and the data fault address register (the access address). It leaves the instruction status register unchanged. It writes the instruction fault address register only when a maintenance operation is flagged.
- R6: If a data-side abort whose winning cause is in the walk class (flags 2 to 6) occurs while an instruction-cache maintenance operation is flagged, the data status gets code 00100 with the domain field and bit 12 both zero. The instruction status gets the real cause, and both address registers are written.
- R7: An instruction-side abort writes only the instruction status register. Alignment and imprecise-external flags are ignored on that side. If only ignored flags are high, nothing changes and no pulse is raised.
- R8: All four registers reset to zero and hold their value in any cycle without an accepted fault.
- R9: The abort-taken output is high for exactly the one cycle after each edge that updates the registers.
- R10: Status bits 31:13, 11 and 9:8 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| causeFlags | input | 11 | Per-cause fault flags, bit 0 highest priority |
| instrSide | input | 1 | 1 = instruction-side access, 0 = data-side |
| isPage | input | 1 | Fault hit a page mapping (0 = section) |
| secondLvl | input | 1 | Walk external abort was on the second-level fetch |
| busSlaveErr | input | 1 | External abort kind: 1 slave error, 0 decode error |
| maintOp | input | 1 | Access is a cache maintenance operation by address |
| maintICache | input | 1 | That maintenance operation targets the instruction cache |
| domainNum | input | 4 | Domain of the faulting mapping |
| accessAddr | input | ADDR_W | Virtual address of the access |
| instrAddr | input | ADDR_W | Address of the issuing instruction |
| dataStatus | output | 32 | Data-side fault status register |
| instrStatus | output | 32 | Instruction-side fault status register |
| dataAddr | output | ADDR_W | Data fault address register |
| instrFaultAddr | output | ADDR_W | Instruction fault address register |
| abortTaken | output | 1 | One-cycle pulse after each register update |

## Verification
A wrong pick in the priority logic shows at the status port one cycle after the stimulus edge, as a code for a lower-ranked cause. A wrong write strobe shows in the same cycle as a register that changed when it should have held, or held when it should have changed. The pulse output shows it too. Faults in the two-sided maintenance case appear as a mismatch between the two status words in that same cycle. The reference model compares all five outputs after every edge, so any state error surfaces within one clock.

// File: rtl/faultRecPkg.sv
package faultRecPkg;

  localparam int NUM_CAUSES = 11;
  localparam int FSR_W      = 32;
  localparam int DOM_W      = 4;
  localparam int CODE_W     = 5;

  typedef enum logic [3:0] {
    CAUSE_ALIGN     = 4'd0,
    CAUSE_TLBMISS   = 4'd1,
    CAUSE_WALKEXT   = 4'd2,
    CAUSE_XLAT      = 4'd3,
    CAUSE_ACCFLAG   = 4'd4,
    CAUSE_DOMAIN    = 4'd5,
    CAUSE_PERM      = 4'd6,
    CAUSE_PRECEXT   = 4'd7,
    CAUSE_IMPRECEXT = 4'd8,
    CAUSE_PARITY    = 4'd9,
    CAUSE_DEBUG     = 4'd10,
    CAUSE_NONE      = 4'd15
  } cause_e;

  localparam logic [CODE_W-1:0] MAINT_CODE = 5'b00100;

  // Causes that the instruction side can report
  localparam logic [NUM_CAUSES-1:0] INSTR_ELIGIBLE =
    ~((NUM_CAUSES'(1) << CAUSE_ALIGN) | (NUM_CAUSES'(1) << CAUSE_IMPRECEXT));

  typedef struct packed {
    logic   dataWrite;
    logic   instrWrite;
    logic   iAddrWrite;
    logic   maintCode;
    cause_e dataCause;
    cause_e instrCause;
  } strobe_t;

  function automatic cause_e pickHighest(logic [NUM_CAUSES-1:0] v);
    cause_e r;
    r = CAUSE_NONE;
    for (int i = NUM_CAUSES - 1; i >= 0; i--) begin
      if (v[i]) r = cause_e'(i);
    end
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] causeCode(cause_e c, logic isPage, logic secondLvl);
    case (c)
      CAUSE_ALIGN:     return 5'b00001;
      CAUSE_TLBMISS:   return 5'b00000;
      CAUSE_WALKEXT:   return secondLvl ? 5'b01110 : 5'b01100;
      CAUSE_XLAT:      return isPage ? 5'b00111 : 5'b00101;
      CAUSE_ACCFLAG:   return isPage ? 5'b00110 : 5'b00011;
      CAUSE_DOMAIN:    return isPage ? 5'b01011 : 5'b01001;
      CAUSE_PERM:      return isPage ? 5'b01111 : 5'b01101;
      CAUSE_PRECEXT:   return 5'b01000;
      CAUSE_IMPRECEXT: return 5'b10110;
      CAUSE_PARITY:    return 5'b11000;
      CAUSE_DEBUG:     return 5'b00010;
      default:         return 5'b00000;
    endcase
  endfunction

  function automatic logic domainValid(cause_e c, logic isPage, logic secondLvl);
    case (c)
      CAUSE_WALKEXT:                         return secondLvl;
      CAUSE_XLAT:                            return isPage;
      CAUSE_ACCFLAG, CAUSE_DOMAIN, CAUSE_PERM,
      CAUSE_DEBUG:                           return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

  function automatic logic isExternal(cause_e c);
    return (c == CAUSE_WALKEXT) || (c == CAUSE_PRECEXT) || (c == CAUSE_IMPRECEXT);
  endfunction

  function automatic logic [FSR_W-1:0] packFsr(logic [CODE_W-1:0] code,
                                               logic [DOM_W-1:0] dom, logic slv);
    logic [FSR_W-1:0] w;
    w        = '0;
    w[3:0]   = code[3:0];
    w[7:4]   = dom;
    w[10]    = code[4];
    w[12]    = slv;
    return w;
  endfunction

endpackage

// File: rtl/faultRecCtrl.sv
module faultRecCtrl
  import faultRecPkg::*;
(
  input  logic [NUM_CAUSES-1:0] causeFlags,
  input  logic                  instrSide,
  input  logic                  maintOp,
  input  logic                  maintICache,
  output strobe_t               strobes
);

  logic [NUM_CAUSES-1:0] instrFlags;
  cause_e dataPick;
  cause_e instrPick;
  logic   walkClass;
  logic   dataHit;

  always_comb begin
    instrFlags = causeFlags & INSTR_ELIGIBLE;
    dataPick   = pickHighest(causeFlags);
    instrPick  = pickHighest(instrFlags);
    walkClass  = (dataPick >= CAUSE_WALKEXT) && (dataPick <= CAUSE_PERM);
    dataHit    = !instrSide && (dataPick != CAUSE_NONE);

    strobes            = '0;
    strobes.dataCause  = dataPick;
    strobes.instrCause = instrPick;
    if (instrSide) begin
      strobes.instrWrite = (instrPick != CAUSE_NONE);
    end else begin
      strobes.dataWrite  = dataHit;
      strobes.iAddrWrite = dataHit && maintOp;
      strobes.maintCode  = dataHit && maintOp && maintICache && walkClass;
      strobes.instrWrite = strobes.maintCode;
    end
  end

endmodule

// File: rtl/faultRecDatapath.sv
module faultRecDatapath
  import faultRecPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              isPage,
  input  logic              secondLvl,
  input  logic              busSlaveErr,
  input  logic [DOM_W-1:0]  domainNum,
  input  logic [ADDR_W-1:0] accessAddr,
  input  logic [ADDR_W-1:0] instrAddr,
  output logic [FSR_W-1:0]  dataStatus,
  output logic [FSR_W-1:0]  instrStatus,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [ADDR_W-1:0] instrFaultAddr,
  output logic              abortTaken
);

  logic [FSR_W-1:0] dataNext;
  logic [FSR_W-1:0] instrNext;
  logic [DOM_W-1:0] dataDom;

  always_comb begin
    dataDom = domainValid(strobes.dataCause, isPage, secondLvl) ? domainNum : '0;
    if (strobes.maintCode) begin
      dataNext = packFsr(MAINT_CODE, '0, 1'b0);
    end else begin
      dataNext = packFsr(causeCode(strobes.dataCause, isPage, secondLvl), dataDom,
                         isExternal(strobes.dataCause) && busSlaveErr);
    end
    instrNext = packFsr(causeCode(strobes.instrCause, isPage, secondLvl), '0,
                        isExternal(strobes.instrCause) && busSlaveErr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataStatus     <= '0;
      instrStatus    <= '0;
      dataAddr       <= '0;
      instrFaultAddr <= '0;
      abortTaken     <= 1'b0;
    end else begin
      abortTaken <= strobes.dataWrite || strobes.instrWrite;
      if (strobes.dataWrite) begin
        dataStatus <= dataNext;
        dataAddr   <= accessAddr;
      end
      if (strobes.instrWrite) instrStatus <= instrNext;
      if (strobes.iAddrWrite) instrFaultAddr <= instrAddr;
    end
  end

endmodule

// File: rtl/faultRecorder.sv
module faultRecorder
  import faultRecPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CAUSES-1:0] causeFlags,
  input  logic                  instrSide,
  input  logic                  isPage,
  input  logic                  secondLvl,
  input  logic                  busSlaveErr,
  input  logic                  maintOp,
  input  logic                  maintICache,
  input  logic [DOM_W-1:0]      domainNum,
  input  logic [ADDR_W-1:0]     accessAddr,
  input  logic [ADDR_W-1:0]     instrAddr,
  output logic [FSR_W-1:0]      dataStatus,
  output logic [FSR_W-1:0]      instrStatus,
  output logic [ADDR_W-1:0]     dataAddr,
  output logic [ADDR_W-1:0]     instrFaultAddr,
  output logic                  abortTaken
);

  strobe_t strobes;

  faultRecCtrl ctrl (
    .causeFlags (causeFlags),
    .instrSide  (instrSide),
    .maintOp    (maintOp),
    .maintICache(maintICache),
    .strobes    (strobes)
  );

  faultRecDatapath #(.ADDR_W(ADDR_W)) dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .isPage        (isPage),
    .secondLvl     (secondLvl),
    .busSlaveErr   (busSlaveErr),
    .domainNum     (domainNum),
    .accessAddr    (accessAddr),
    .instrAddr     (instrAddr),
    .dataStatus    (dataStatus),
    .instrStatus   (instrStatus),
    .dataAddr      (dataAddr),
    .instrFaultAddr(instrFaultAddr),
    .abortTaken    (abortTaken)
  );

endmodule

// File: rtl/faultRecorderChk.sv
module faultRecorderChk
  import faultRecPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_CAUSES-1:0] causeFlags,
  input logic                  instrSide,
  input logic [FSR_W-1:0]      dataStatus,
  input logic [FSR_W-1:0]      instrStatus,
  input logic [ADDR_W-1:0]     dataAddr,
  input logic [ADDR_W-1:0]     instrFaultAddr,
  input logic                  abortTaken
);

  logic [CODE_W-1:0] dataCodeSeen;
  assign dataCodeSeen = {dataStatus[10], dataStatus[3:0]};

  // R9
  pulse_after_data_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|causeFlags) && !instrSide) |=> abortTaken);

  // R8
  hold_without_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !abortTaken |-> ($stable(dataStatus) && $stable(instrStatus) &&
                     $stable(dataAddr) && $stable(instrFaultAddr)));

  // R7
  instr_abort_spares_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abortTaken && $past(instrSide)) |-> ($stable(dataStatus) && $stable(dataAddr)));

  // R10
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dataStatus & 32'hFFFF_EB00) == '0) && ((instrStatus & 32'hFFFF_EB00) == '0));

  // R3
  instr_domain_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrStatus[7:4] == '0);

  // R4
  slave_bit_external_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataStatus[12] |-> (dataCodeSeen == 5'b01100 || dataCodeSeen == 5'b01110 ||
                        dataCodeSeen == 5'b01000 || dataCodeSeen == 5'b10110));

endmodule

bind faultRecorder faultRecorderChk #(.ADDR_W(ADDR_W)) chkInst (
  .clk           (clk),
  .rstN          (rstN),
  .causeFlags    (causeFlags),
  .instrSide     (instrSide),
  .dataStatus    (dataStatus),
  .instrStatus   (instrStatus),
  .dataAddr      (dataAddr),
  .instrFaultAddr(instrFaultAddr),
  .abortTaken    (abortTaken)
);

// File: tb/faultRecorder_test.sv
module faultRecorder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] causeFlags = '0;
  logic        instrSide = 1'b0, isPage = 1'b0, secondLvl = 1'b0, busSlaveErr = 1'b0;
  logic        maintOp = 1'b0, maintICache = 1'b0;
  logic [3:0]  domainNum = '0;
  logic [31:0] accessAddr = '0, instrAddr = '0;
  logic [31:0] dataStatus, instrStatus, dataAddr, instrFaultAddr;
  logic        abortTaken;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] eD = '0, eI = '0, eDa = '0, eIa = '0;
  logic        eP = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  faultRecorder uut (
    .clk(clk), .rstN(rstN), .causeFlags(causeFlags), .instrSide(instrSide),
    .isPage(isPage), .secondLvl(secondLvl), .busSlaveErr(busSlaveErr),
    .maintOp(maintOp), .maintICache(maintICache), .domainNum(domainNum),
    .accessAddr(accessAddr), .instrAddr(instrAddr), .dataStatus(dataStatus),
    .instrStatus(instrStatus), .dataAddr(dataAddr), .instrFaultAddr(instrFaultAddr),
    .abortTaken(abortTaken)
  );

  function automatic logic [4:0] refCode(int c, logic pg, logic sl);
    case (c)
      0: return 5'b00001;   1: return 5'b00000;
      2: return sl ? 5'b01110 : 5'b01100;
      3: return pg ? 5'b00111 : 5'b00101;
      4: return pg ? 5'b00110 : 5'b00011;
      5: return pg ? 5'b01011 : 5'b01001;
      6: return pg ? 5'b01111 : 5'b01101;
      7: return 5'b01000;   8: return 5'b10110;
      9: return 5'b11000;   default: return 5'b00010;
    endcase
  endfunction

  function automatic logic [31:0] refFsr(logic [4:0] code, logic [3:0] dom, logic slv);
    return (32'(slv) << 12) | (32'(code[4]) << 10) | (32'(dom) << 4) | 32'(code[3:0]);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    int pick = -1;
    logic ext, domOk;
    eP = 1'b0;
    for (int i = 0; i < 11; i++)
      if (pick < 0 && causeFlags[i] && (!instrSide || (i != 0 && i != 8))) pick = i;
    if (pick >= 0) begin
      eP    = 1'b1;
      ext   = (pick == 2) || (pick == 7) || (pick == 8);
      domOk = (pick == 2 && secondLvl) || (pick == 3 && isPage) ||
              (pick >= 4 && pick <= 6) || (pick == 10);
      if (instrSide) begin
        eI = refFsr(refCode(pick, isPage, secondLvl), 4'd0, ext && busSlaveErr);
      end else begin
        eDa = accessAddr;
        if (maintOp) eIa = instrAddr;
        if (maintOp && maintICache && pick >= 2 && pick <= 6) begin
          eD = refFsr(5'b00100, 4'd0, 1'b0);
          eI = refFsr(refCode(pick, isPage, secondLvl), 4'd0, ext && busSlaveErr);
        end else begin
          eD = refFsr(refCode(pick, isPage, secondLvl), domOk ? domainNum : 4'd0,
                      ext && busSlaveErr);
        end
      end
    end
  endtask

  task automatic compareAll();
    check("R2 dataStatus", dataStatus, eD);
    check("R7 instrStatus", instrStatus, eI);
    check("R5 dataAddr", dataAddr, eDa);
    check("R6 instrFaultAddr", instrFaultAddr, eIa);
    check("R9 abortTaken", 32'(abortTaken), 32'(eP));
    check("R10 spare bits", (dataStatus | instrStatus) & 32'hFFFF_EB00, 32'h0);
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic setAccess(logic [10:0] f, logic iS, logic pg, logic sl, logic slv,
                           logic mo, logic mi, logic [3:0] dom);
    causeFlags = f; instrSide = iS; isPage = pg; secondLvl = sl; busSlaveErr = slv;
    maintOp = mo; maintICache = mi; domainNum = dom;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    compareAll();
    check("R8 reset dataStatus", dataStatus, 32'h0);
    rstN = 1'b1;
    accessAddr = 32'h1000_0040; instrAddr = 32'h0000_8000;

    // R1: alignment beats permission
    setAccess(11'b000_0100_0001, 0, 1, 0, 0, 0, 0, 4'd7); tick();
    check("R1 align wins", dataStatus, 32'h0000_0001);
    // R9: pulse falls on an idle cycle; R8 hold
    setAccess('0, 0, 0, 0, 0, 0, 0, 4'd0); accessAddr = 32'hDEAD_0000; tick();
    check("R9 pulse ends", 32'(abortTaken), 32'h0);
    check("R8 hold dataAddr", dataAddr, 32'h1000_0040);

    // R2/R3: page permission with domain 5
    accessAddr = 32'h2000_0010;
    setAccess(11'b000_0100_0000, 0, 1, 0, 0, 0, 0, 4'd5); tick();
    check("R3 page permission domain", dataStatus, 32'h0000_005F);
    // R3: section translation leaves domain zero
    setAccess(11'b000_0000_1000, 0, 0, 0, 0, 0, 0, 4'd9); tick();
    check("R3 section translation no domain", dataStatus, 32'h0000_0005);
    // R4: precise slave error, imprecise decode error
    setAccess(11'b000_1000_0000, 0, 0, 0, 1, 0, 0, 4'd2); tick();
    check("R4 precise slave", dataStatus, 32'h0000_1008);
    setAccess(11'b001_0000_0000, 0, 0, 0, 0, 0, 0, 4'd2); tick();
    check("R4 imprecise decode", dataStatus, 32'h0000_0406);
    // R4: slave kind ignored for a non-external cause
    setAccess(11'b000_0010_0000, 0, 0, 0, 1, 0, 0, 4'd1); tick();
    check("R4 domain fault bit12 zero", dataStatus, 32'h0000_0019);

    // R6: instruction-cache maintenance with page translation
    accessAddr = 32'h3000_0100; instrAddr = 32'h0000_9004;
    setAccess(11'b000_0000_1000, 0, 1, 0, 0, 1, 1, 4'd3); tick();
    check("R6 data side maint code", dataStatus, 32'h0000_0004);
    check("R6 instr side real cause", instrStatus, 32'h0000_0007);
    check("R6 ifar", instrFaultAddr, 32'h0000_9004);
    // R5: plain data abort leaves ifar and ifsr alone
    accessAddr = 32'h4000_0000; instrAddr = 32'h0000_A000;
    setAccess(11'b000_0001_0000, 0, 0, 0, 0, 0, 0, 4'd6); tick();
    check("R5 ifar kept", instrFaultAddr, 32'h0000_9004);
    check("R5 ifsr kept", instrStatus, 32'h0000_0007);

    // R7: only ignored causes on the instruction side
    setAccess(11'b001_0000_0001, 1, 0, 0, 0, 0, 0, 4'd4); tick();
    check("R7 ignored causes no pulse", 32'(abortTaken), 32'h0);
    check("R7 ignored causes ifsr kept", instrStatus, 32'h0000_0007);
    // R7: debug event wins over ignored alignment, no domain recorded
    setAccess(11'b100_0000_0001, 1, 0, 0, 0, 0, 0, 4'd4); tick();
    check("R7 instr debug", instrStatus, 32'h0000_0002);
    check("R7 dataStatus kept", dataStatus, 32'h0000_0063);

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [10:0] f;
      f = ($urandom_range(0, 3) == 0) ? 11'($urandom) : ((11'($urandom)) & 11'($urandom));
      if ($urandom_range(0, 4) == 0) f = '0;
      setAccess(f, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1'($urandom), 4'($urandom));
      accessAddr = $urandom; instrAddr = $urandom;
      tick();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule